// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming frame is kept, judging only by its 48-bit destination address. Three sources can accept an address: a bank of sixteen exact-match slots, a 512-bit group-address hash table, and three mode bits (promiscuous, broadcast, all-multicast). A second 512-bit hash table, laid out like the first, does not decide acceptance. Instead it raises a priority flag on accepted group frames, so that later stages can steer them to a faster queue.

Each lookup starts with a one-cycle strobe carrying the address. The hash index is the top nine bits of a CRC-32. The CRC starts at all ones and runs bit-serially over the six address bytes, least-significant bit of each byte first. The block folds one byte into it per clock, so the verdict always appears a fixed number of cycles after the strobe. Slots, hash words and mode bits are loaded through a narrow synchronous write port with one 16-bit word per write.

Top module: `rx_addr_filter`

## Requirements
- R1: Write address map: `cfg_wr_addr[7:6]=00` selects a slot, with slot number `cfg_wr_addr[5:2]` and part `cfg_wr_addr[1:0]`. Part 0 holds bytes 4-5 (`dst_addr[15:0]`), part 1 holds bytes 2-3 (`dst_addr[31:16]`), part 2 holds bytes 0-1 (`dst_addr[47:32]`), and part 3 is ignored. `0x40+w` writes filter hash word w, `0x60+w` writes priority hash word w, and `0x80` writes the mode bits. Address byte 0 is `dst_addr[47:40]`.
- R2: An address equal to any programmed slot (0 to 15) is accepted, whether unicast or group.
- R3: A slot holding all zeros never matches, so the all-zero address is not accepted through it.
- R4: An address with `dst_addr[40]=0` (unicast) is accepted only on a slot match or in promiscuous mode. Neither hash hits nor all-multicast accept it.
- R5: For the hash index, CRC = all ones at the start. For every address bit (byte 0 to byte 5, LSB first), carry = CRC[31] xor bit, then CRC is shifted left by one, and if carry is 1 the CRC is XORed with 0x04C11DB6 and bit 0 is set. The index is CRC[31:23]. A group address is accepted when bit index[3:0] of filter hash word index[8:4] is set.
- R6: `high_prio` is 1 only for an accepted group address whose bit in the priority hash table is set. The priority table on its own never causes acceptance.
- R7: Mode bit 0 (promiscuous) accepts every address.
- R8: Mode bit 1 accepts the all-ones address. Mode bit 2 accepts every group address.
- R9: `result_valid` is a one-cycle pulse on the 6th rising edge after the edge that sampled an accepted strobe. `accept` and `high_prio` keep their values until the next result.
- R10: A strobe sampled on any of the six edges after an accepted strobe is ignored. It neither alters the pending result nor produces an extra result.
- R11: A write is seen by any result registered on a later edge. A write that lands on the very edge that registers a result is not seen by that result.
- R12: Reset clears all slots, both hash tables, the mode bits and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_valid | input | 1 | Lookup strobe, one cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| cfg_wr_en | input | 1 | Table/mode write enable |
| cfg_wr_addr | input | 8 | Write word address (map in R1) |
| cfg_wr_data | input | 16 | Write data |
| result_valid | output | 1 | Verdict strobe |
| accept | output | 1 | Frame accepted |
| high_prio | output | 1 | Accepted group frame hit the priority table |

## Verification
Two things can coincide in one cycle: a table write, and the edge on which a pending lookup registers its verdict. The bench starts a lookup for a group address whose hash bit is clear. It then drives the write that sets that bit in the cycle ending at the verdict edge. That verdict must still reject, and a repeat lookup right afterwards must accept. The bench also drives a second strobe into an in-flight lookup and judges the result by the first address alone, with no further pulse.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB6;

  typedef struct packed {
    logic allmulti;
    logic bcast;
    logic promisc;
  } mode_t;

  // Fold one byte into the hash CRC, least-significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] seed, input logic [7:0] data);
    logic [31:0] c;
    logic        carry;
    c = seed;
    for (int j = 0; j < 8; j++) begin
      carry = c[31] ^ data[j];
      c     = {c[30:0], 1'b0};
      if (carry) c = (c ^ CRC_POLY) | 32'h1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_crc_engine.sv
module rxf_crc_engine
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  hash_idx
);
  localparam int BYTES = ADDR_W / 8;
  localparam int CNT_W = $clog2(BYTES + 1);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [31:0]      crc_q, crc_n;
  logic             crc_en, start_ok;
  logic [ADDR_W-1:0] shifted;
  logic [7:0]       byte_sel;

  assign start_ok = start && !busy_q;
  assign done     = busy_q && (cnt_q == CNT_W'(BYTES));
  assign shifted  = addr_q << {cnt_q, 3'b000};
  assign byte_sel = shifted[ADDR_W-1 -: 8];
  assign hash_idx = crc_q[31 -: IDX_W];

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    crc_n  = crc_q;
    crc_en = 1'b0;
    if (start_ok) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(1);
      crc_n  = crc_byte('1, addr_in[ADDR_W-1 -: 8]);
      crc_en = 1'b1;
    end else if (busy_q) begin
      if (done) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n  = cnt_q + CNT_W'(1);
        crc_n  = crc_byte(crc_q, byte_sel);
        crc_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      if (crc_en)   crc_q  <= crc_n;
      if (start_ok) addr_q <= addr_in;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(addr_q)); // R10

endmodule

// File: rtl/rxf_exact_table.sv
module rxf_exact_table #(
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 48,
  parameter int HW        = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_slot,
  input  logic [1:0]                   wr_part,
  input  logic [HW-1:0]                wr_data,
  input  logic [ADDR_W-1:0]            lookup_addr,
  output logic                         hit
);
  localparam int PARTS  = ADDR_W / HW;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] val_q;
    logic              sel;
    assign sel = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (sel) begin
        for (int p = 0; p < PARTS; p++) begin
          if (wr_part == 2'(p)) val_q[p*HW +: HW] <= wr_data;
        end
      end
    end

    assign hit_vec[s] = (val_q == lookup_addr) && (|val_q);
  end

  assign hit = |hit_vec;

  AST_ZERO_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (|lookup_addr)); // R3

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int WORDS = 32,
  parameter int WW    = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [$clog2(WORDS)-1:0]               wr_word,
  input  logic [WW-1:0]                          wr_data,
  input  logic [$clog2(WORDS)+$clog2(WW)-1:0]    lookup_idx,
  output logic                                   bit_hit
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(WW);
  localparam int IDX_W  = WSEL_W + BSEL_W;

  logic [WW-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   word_q <= '0;
      else if (wr_en && (wr_word == WSEL_W'(w)))    word_q <= wr_data;
    end
    assign words[w] = word_q;
  end

  assign bit_hit = words[lookup_idx[IDX_W-1 -: WSEL_W]][lookup_idx[BSEL_W-1:0]];

  AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words[$past(wr_word)] == $past(wr_data))); // R11

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int HASH_WORDS = 32,
  parameter int ADDR_W     = 48,
  parameter int HWORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [47:0]       dst_addr,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_addr,
  input  logic [15:0]       cfg_wr_data,
  output logic              result_valid,
  output logic              accept,
  output logic              high_prio
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int WSEL_W = $clog2(HASH_WORDS);
  localparam int IDX_W  = WSEL_W + $clog2(HWORD_W);
  localparam int MC_BIT = ADDR_W - 8;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Write decode
  logic slot_we, fhash_we, phash_we, mode_we;
  assign slot_we  = cfg_wr_en && (cfg_wr_addr[7:6] == 2'b00);
  assign fhash_we = cfg_wr_en && (cfg_wr_addr[7:5] == 3'b010);
  assign phash_we = cfg_wr_en && (cfg_wr_addr[7:5] == 3'b011);
  assign mode_we  = cfg_wr_en && (cfg_wr_addr == 8'h80);

  mode_t mode_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mode_q <= '0;
    else if (mode_we) mode_q <= mode_t'(cfg_wr_data[2:0]);
  end

  // Hash engine
  logic              done;
  logic [ADDR_W-1:0] lookup_addr;
  logic [IDX_W-1:0]  hash_idx;

  rxf_crc_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_int_n), .start(dst_valid), .addr_in(dst_addr),
    .done(done), .addr_q(lookup_addr), .hash_idx(hash_idx)
  );

  logic slot_hit, fhash_hit, phash_hit;

  rxf_exact_table #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .HW(HWORD_W)) u_slots (
    .clk(clk), .rst_n(rst_int_n), .wr_en(slot_we),
    .wr_slot(cfg_wr_addr[2 +: SLOT_W]), .wr_part(cfg_wr_addr[1:0]),
    .wr_data(cfg_wr_data), .lookup_addr(lookup_addr), .hit(slot_hit)
  );

  rxf_hash_table #(.WORDS(HASH_WORDS), .WW(HWORD_W)) u_fhash (
    .clk(clk), .rst_n(rst_int_n), .wr_en(fhash_we),
    .wr_word(cfg_wr_addr[WSEL_W-1:0]), .wr_data(cfg_wr_data),
    .lookup_idx(hash_idx), .bit_hit(fhash_hit)
  );

  rxf_hash_table #(.WORDS(HASH_WORDS), .WW(HWORD_W)) u_phash (
    .clk(clk), .rst_n(rst_int_n), .wr_en(phash_we),
    .wr_word(cfg_wr_addr[WSEL_W-1:0]), .wr_data(cfg_wr_data),
    .lookup_idx(hash_idx), .bit_hit(phash_hit)
  );

  // Verdict
  logic is_group, is_bcast, acc_n, prio_n;
  logic rv_q, acc_q, prio_q;

  always_comb begin
    is_group = lookup_addr[MC_BIT];
    is_bcast = &lookup_addr;
    acc_n    = mode_q.promisc
             | slot_hit
             | (is_group & (mode_q.allmulti | fhash_hit))
             | (is_bcast & mode_q.bcast);
    prio_n   = acc_n & is_group & phash_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rv_q   <= 1'b0;
      acc_q  <= 1'b0;
      prio_q <= 1'b0;
    end else begin
      rv_q <= done;
      if (done) begin
        acc_q  <= acc_n;
        prio_q <= prio_n;
      end
    end
  end

  assign result_valid = rv_q;
  assign accept       = acc_q;
  assign high_prio    = prio_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_valid |=> !result_valid); // R9
  AST_PRIO_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (result_valid && high_prio) |-> accept); // R6
  AST_UNICAST_GUARD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (result_valid && accept && !$past(mode_q.promisc) && !$past(lookup_addr[MC_BIT]))
      |-> $past(slot_hit)); // R4

endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dst_valid;
  logic [47:0] dst_addr;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_addr;
  logic [15:0] cfg_wr_data;
  logic        result_valid, accept, high_prio;

  int checks = 0;
  int fails  = 0;

  logic [15:0] fh [32];
  logic [15:0] ph [32];

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .result_valid(result_valid), .accept(accept), .high_prio(high_prio)
  );

  // {mode[2:0], address, expected accept, expected priority}
  localparam logic [52:0] VEC [12] = '{
    {3'd0, 48'h021122334455, 1'b1, 1'b0},
    {3'd0, 48'h021122334456, 1'b0, 1'b0},
    {3'd0, 48'h01005E0000FB, 1'b1, 1'b0},
    {3'd0, 48'hFFFFFFFFFFFF, 1'b0, 1'b0},
    {3'd2, 48'hFFFFFFFFFFFF, 1'b1, 1'b0},
    {3'd2, 48'h01005E000001, 1'b0, 1'b0},
    {3'd4, 48'h01005E000001, 1'b1, 1'b0},
    {3'd4, 48'h02AABBCCDDEE, 1'b0, 1'b0},
    {3'd1, 48'h02AABBCCDDEE, 1'b1, 1'b0},
    {3'd0, 48'h000000000000, 1'b0, 1'b0},
    {3'd4, 48'hFFFFFFFFFFFF, 1'b1, 1'b0},
    {3'd0, 48'h020000000F0F, 1'b1, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2, 11: return "R2";
      3, 4, 5, 6, 10: return "R8";
      7: return "R4";
      8: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [8:0] ref_idx(logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        cy;
    c = '1;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        cy = c[31] ^ b[j];
        c  = {c[30:0], 1'b0};
        if (cy) c = (c ^ 32'h04C11DB6) | 32'h1;
      end
    end
    return c[31:23];
  endfunction

  function automatic logic [47:0] find_free(logic [47:0] base);
    logic [8:0] ix;
    for (int k = 0; k < 256; k++) begin
      ix = ref_idx(base + 48'(k));
      if (!fh[ix[8:4]][ix[3:0]] && !ph[ix[8:4]][ix[3:0]]) return base + 48'(k);
    end
    return base;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_slot(int s, logic [47:0] a);
    wr(8'(s*4 + 0), a[15:0]);
    wr(8'(s*4 + 1), a[31:16]);
    wr(8'(s*4 + 2), a[47:32]);
  endtask

  task automatic set_hash(bit prio, logic [47:0] a);
    logic [8:0] ix;
    ix = ref_idx(a);
    if (prio) begin
      ph[ix[8:4]][ix[3:0]] = 1'b1;
      wr(8'h60 + 8'(ix[8:4]), ph[ix[8:4]]);
    end else begin
      fh[ix[8:4]][ix[3:0]] = 1'b1;
      wr(8'h40 + 8'(ix[8:4]), fh[ix[8:4]]);
    end
  endtask

  task automatic lookup(logic [47:0] a, output logic acc, output logic pri);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    dst_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R9", "valid early", 64'(result_valid), 64'd0);
    @(negedge clk);
    check("R9", "valid at 6", 64'(result_valid), 64'd1);
    acc = accept; pri = high_prio;
    @(negedge clk);
    check("R9", "valid pulse width", 64'(result_valid), 64'd0);
    check("R9", "accept held", 64'(accept), 64'(acc));
  endtask

  task automatic expect_lookup(string tag, logic [47:0] a, logic ea, logic ep);
    logic ga, gp;
    lookup(a, ga, gp);
    check(tag, $sformatf("accept %h", a), 64'(ga), 64'(ea));
    check(tag, $sformatf("prio %h", a), 64'(gp), 64'(ep));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] h1, h2, uc, p1, m4;
    int pulses;
    for (int w = 0; w < 32; w++) begin fh[w] = '0; ph[w] = '0; end
    rst_n = 1'b0; dst_valid = 1'b0; dst_addr = '0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    repeat (3) @(negedge clk);
    check("R12", "reset valid", 64'(result_valid), 64'd0);
    check("R12", "reset accept", 64'(accept), 64'd0);
    check("R12", "reset prio", 64'(high_prio), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_lookup("R12", 48'h021122334455, 1'b0, 1'b0);

    set_slot(0, 48'h021122334455);
    set_slot(5, 48'h01005E0000FB);
    set_slot(15, 48'h020000000F0F);
    for (int i = 0; i < 12; i++) begin
      wr(8'h80, {13'd0, VEC[i][52:50]});
      expect_lookup(vec_tag(i), VEC[i][49:2], VEC[i][1], VEC[i][0]);
    end
    wr(8'h80, 16'h0);

    // R1: part order, part 3 ignored
    wr(8'h1C, 16'h89AB); wr(8'h1D, 16'h4567); wr(8'h1E, 16'h0123); wr(8'h1F, 16'hFFFF);
    expect_lookup("R1", 48'h0123456789AB, 1'b1, 1'b0);
    expect_lookup("R1", 48'h89AB45670123, 1'b0, 1'b0);

    // R3: zeroed slot 0 no longer matches anything
    set_slot(0, 48'h0);
    expect_lookup("R3", 48'h000000000000, 1'b0, 1'b0);
    expect_lookup("R3", 48'h021122334455, 1'b0, 1'b0);
    set_slot(0, 48'h021122334455);

    // R5: hash hit and miss
    h1 = find_free(48'h01005E000100);
    set_hash(1'b0, h1);
    expect_lookup("R5", h1, 1'b1, 1'b0);
    h2 = find_free(48'h01005E000200);
    expect_lookup("R5", h2, 1'b0, 1'b0);

    // R4: unicast with its hash bit set is still rejected
    uc = find_free(48'h02005E000300);
    set_hash(1'b0, uc);
    expect_lookup("R4", uc, 1'b0, 1'b0);

    // R6: priority table alone, then with filter bit
    p1 = find_free(48'h01005E000400);
    set_hash(1'b1, p1);
    expect_lookup("R6", p1, 1'b0, 1'b0);
    set_hash(1'b0, p1);
    expect_lookup("R6", p1, 1'b1, 1'b1);

    // R11: write landing on the verdict edge is not seen
    m4 = find_free(48'h01005E000500);
    @(negedge clk); dst_valid = 1'b1; dst_addr = m4;
    @(negedge clk); dst_valid = 1'b0;
    repeat (5) @(negedge clk);
    begin
      logic [8:0] ix;
      ix = ref_idx(m4);
      fh[ix[8:4]][ix[3:0]] = 1'b1;
      cfg_wr_en = 1'b1; cfg_wr_addr = 8'h40 + 8'(ix[8:4]); cfg_wr_data = fh[ix[8:4]];
    end
    @(negedge clk); cfg_wr_en = 1'b0;
    check("R11", "same-edge valid", 64'(result_valid), 64'd1);
    check("R11", "same-edge accept", 64'(accept), 64'd0);
    expect_lookup("R11", m4, 1'b1, 1'b0);

    // R10: strobe during a lookup is ignored
    @(negedge clk); dst_valid = 1'b1; dst_addr = 48'h02DEAD000001;
    @(negedge clk); dst_valid = 1'b0;
    repeat (2) @(negedge clk);
    dst_valid = 1'b1; dst_addr = 48'h021122334455;
    @(negedge clk); dst_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "no early valid", 64'(result_valid), 64'd0);
    @(negedge clk);
    check("R10", "first result valid", 64'(result_valid), 64'd1);
    check("R10", "first result accept", 64'(accept), 64'd0);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (result_valid) pulses++;
    end
    check("R10", "extra pulses", 64'(pulses), 64'd0);

    // R12: reset clears tables and mode
    wr(8'h80, 16'h0002);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", "reset accept", 64'(accept), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_lookup("R12", 48'h021122334455, 1'b0, 1'b0);
    expect_lookup("R12", 48'hFFFFFFFFFFFF, 1'b0, 1'b0);
    expect_lookup("R12", h1, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule